// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

The block sits between two 16-bit ports, A and B, and moves data between them in both directions. Each direction has its own bank of level-sensitive storage and three active-low controls: an enable, a latch-enable and an output-enable. With both the enable and the latch-enable low, a bank is transparent and copies its source port. When the latch-enable rises, the bank freezes the last value it saw. The port on the far side is driven only while that direction's enable and output-enable are both low. With the enable high, the direction ignores its latch-enable and leaves its outputs undriven.

Each port is split into halves of `HALF_W` bits, and every half carries its own set of six controls. A half may be used as an independent narrow transceiver. Setting `gang_i` makes all halves follow the controls of half 0, so the block then acts as one wide unit. The bidirectional pins are modelled as an input, an output value and a per-half drive enable for each port, so the tristate buffer itself can sit at the pad.

If both directions drive the same half at once, a per-half clash flag goes high. The block has no clock and no reset. Latch contents are unknown until the first capture.

Top module: `latched_xcvr`

## Requirements
- R1: The A-to-B bank of a half loads only from `a_i` and appears on `b_o`. The B-to-A bank loads only from `b_i` and appears on `a_o`. Half h covers bits [h*HALF_W +: HALF_W].
- R2: While a half's A-to-B enable and latch-enable are both low, that half of `b_o` equals the same half of `a_i` and follows every change of it.
- R3: After the A-to-B latch-enable rises with the enable low, that half of `b_o` keeps the last captured value, whatever `a_i` then does.
- R4: While a direction's enable is high, its bank ignores the latch-enable and keeps its stored value. This is seen on the output once the enable returns low with the latch-enable high.
- R5: `b_oe[h]` is 1 exactly when the half's A-to-B enable and output-enable are both low. `b_o` shows the bank contents whether or not it is enabled.
- R6: The B-to-A direction follows R2 to R5 using its own enable, latch-enable and output-enable, with `b_i` as its source and `a_o`/`a_oe` as its outputs.
- R7: With `gang_i` low, the controls and data of one half have no effect on the outputs of another half.
- R8: With `gang_i` high, every half uses the controls of half 0. The control inputs of the other halves have no effect.
- R9: `clash_o[h]` is 1 exactly when `a_oe[h]` and `b_oe[h]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gang_i | input | 1 | 1: all halves use the controls of half 0 |
| ab_en_n_i | input | N_HALVES | A-to-B enable per half, active low |
| ab_le_n_i | input | N_HALVES | A-to-B latch-enable per half, active low (transparent when low) |
| ab_oe_n_i | input | N_HALVES | A-to-B output-enable per half, active low |
| ba_en_n_i | input | N_HALVES | B-to-A enable per half, active low |
| ba_le_n_i | input | N_HALVES | B-to-A latch-enable per half, active low |
| ba_oe_n_i | input | N_HALVES | B-to-A output-enable per half, active low |
| a_i | input | N_HALVES*HALF_W | Value sensed on port A |
| b_i | input | N_HALVES*HALF_W | Value sensed on port B |
| a_o | output | N_HALVES*HALF_W | B-to-A bank contents toward port A |
| a_oe | output | N_HALVES | Drive enable for each half of port A |
| b_o | output | N_HALVES*HALF_W | A-to-B bank contents toward port B |
| b_oe | output | N_HALVES | Drive enable for each half of port B |
| clash_o | output | N_HALVES | Both directions drive this half |

## Verification
All 64 combinations of one half's six controls are swept against a different, shifted combination on the other half. The data words vary at each step, and the sweep runs once with `gang_i` low and once with it high. This separates a bank that loads at the wrong level, or from the wrong port, from one that only misroutes its enable to the outputs. It also catches halves that leak into each other and ganging that ignores half 0. Data changes and control changes fall on separate steps. Rising controls are applied before falling ones, so transparency, hold after a latch-enable rise, and the ignored latch-enable under a high enable can each be told apart. Directed sequences add fixed expected values for pass-through, hold, ignored latch-enable, tristating and clash.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;

endpackage

// File: rtl/xcvr_ctrl_sel.sv
module xcvr_ctrl_sel
  import xcvr_pkg::*;
#(
  parameter int N_HALVES = 2
) (
  input  logic                gang_i,
  input  logic [N_HALVES-1:0] en_n_i,
  input  logic [N_HALVES-1:0] le_n_i,
  input  logic [N_HALVES-1:0] oe_n_i,
  output dir_ctrl_t           ctl_o [N_HALVES]
);

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    if (h == 0) begin : g_lead
      assign ctl_o[h].en_n = en_n_i[0];
      assign ctl_o[h].le_n = le_n_i[0];
      assign ctl_o[h].oe_n = oe_n_i[0];
    end else begin : g_follow
      assign ctl_o[h].en_n = gang_i ? en_n_i[0] : en_n_i[h];
      assign ctl_o[h].le_n = gang_i ? le_n_i[0] : le_n_i[h];
      assign ctl_o[h].oe_n = gang_i ? oe_n_i[0] : oe_n_i[h];
    end
  end

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         en_n_i,
  input  logic         le_n_i,
  output logic [W-1:0] q_o
);

  logic open_w;
  assign open_w = ~en_n_i & ~le_n_i;

  always_latch begin
    if (open_w) q_o <= d_i;
  end

endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  dir_ctrl_t         ab_ctl_i,
  input  dir_ctrl_t         ba_ctl_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [HALF_W-1:0] a_o,
  output logic              a_oe,
  output logic [HALF_W-1:0] b_o,
  output logic              b_oe,
  output logic              clash_o
);

  xcvr_latch_bank #(.W(HALF_W)) i_ab_bank (
    .d_i   (a_i),
    .en_n_i(ab_ctl_i.en_n),
    .le_n_i(ab_ctl_i.le_n),
    .q_o   (b_o)
  );

  xcvr_latch_bank #(.W(HALF_W)) i_ba_bank (
    .d_i   (b_i),
    .en_n_i(ba_ctl_i.en_n),
    .le_n_i(ba_ctl_i.le_n),
    .q_o   (a_o)
  );

  logic ab_drive, ba_drive;
  assign ab_drive = ~ab_ctl_i.en_n & ~ab_ctl_i.oe_n;
  assign ba_drive = ~ba_ctl_i.en_n & ~ba_ctl_i.oe_n;

  assign b_oe    = ab_drive;
  assign a_oe    = ba_drive;
  assign clash_o = ab_drive & ba_drive;

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int N_HALVES = 2,
  localparam int BUS_W   = HALF_W * N_HALVES
) (
  input  logic                gang_i,
  input  logic [N_HALVES-1:0] ab_en_n_i,
  input  logic [N_HALVES-1:0] ab_le_n_i,
  input  logic [N_HALVES-1:0] ab_oe_n_i,
  input  logic [N_HALVES-1:0] ba_en_n_i,
  input  logic [N_HALVES-1:0] ba_le_n_i,
  input  logic [N_HALVES-1:0] ba_oe_n_i,
  input  logic [BUS_W-1:0]    a_i,
  input  logic [BUS_W-1:0]    b_i,
  output logic [BUS_W-1:0]    a_o,
  output logic [N_HALVES-1:0] a_oe,
  output logic [BUS_W-1:0]    b_o,
  output logic [N_HALVES-1:0] b_oe,
  output logic [N_HALVES-1:0] clash_o
);

  dir_ctrl_t ab_ctl [N_HALVES];
  dir_ctrl_t ba_ctl [N_HALVES];

  xcvr_ctrl_sel #(.N_HALVES(N_HALVES)) i_ab_sel (
    .gang_i(gang_i),
    .en_n_i(ab_en_n_i),
    .le_n_i(ab_le_n_i),
    .oe_n_i(ab_oe_n_i),
    .ctl_o (ab_ctl)
  );

  xcvr_ctrl_sel #(.N_HALVES(N_HALVES)) i_ba_sel (
    .gang_i(gang_i),
    .en_n_i(ba_en_n_i),
    .le_n_i(ba_le_n_i),
    .oe_n_i(ba_oe_n_i),
    .ctl_o (ba_ctl)
  );

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    xcvr_half #(.HALF_W(HALF_W)) i_half (
      .ab_ctl_i(ab_ctl[h]),
      .ba_ctl_i(ba_ctl[h]),
      .a_i     (a_i[h*HALF_W +: HALF_W]),
      .b_i     (b_i[h*HALF_W +: HALF_W]),
      .a_o     (a_o[h*HALF_W +: HALF_W]),
      .a_oe    (a_oe[h]),
      .b_o     (b_o[h*HALF_W +: HALF_W]),
      .b_oe    (b_oe[h]),
      .clash_o (clash_o[h])
    );
  end

endmodule

// File: rtl/latched_xcvr_chk.sv
module latched_xcvr_chk #(
  parameter int HALF_W   = 8,
  parameter int N_HALVES = 2,
  localparam int BUS_W   = HALF_W * N_HALVES
) (
  input logic                gang_i,
  input logic [N_HALVES-1:0] ab_en_n_i,
  input logic [N_HALVES-1:0] ab_le_n_i,
  input logic [N_HALVES-1:0] ab_oe_n_i,
  input logic [N_HALVES-1:0] ba_en_n_i,
  input logic [N_HALVES-1:0] ba_le_n_i,
  input logic [N_HALVES-1:0] ba_oe_n_i,
  input logic [BUS_W-1:0]    a_i,
  input logic [BUS_W-1:0]    b_i,
  input logic [BUS_W-1:0]    a_o,
  input logic [N_HALVES-1:0] a_oe,
  input logic [BUS_W-1:0]    b_o,
  input logic [N_HALVES-1:0] b_oe,
  input logic [N_HALVES-1:0] clash_o
);

  always_comb begin
    for (int h = 0; h < N_HALVES; h++) begin
      int s;
      s = gang_i ? 0 : h;
      // R2: open A-to-B bank passes port A through to b_o
      if (!ab_en_n_i[s] && !ab_le_n_i[s])
        a_r2_ab_pass: assert (b_o[h*HALF_W +: HALF_W] == a_i[h*HALF_W +: HALF_W])
          else $error("R2 pass-through broken in half %0d", h);
      // R5: no drive toward B unless both A-to-B enables are low
      if (ab_en_n_i[s] || ab_oe_n_i[s])
        a_r5_b_quiet: assert (!b_oe[h])
          else $error("R5 b_oe set while disabled in half %0d", h);
      // R6: mirror for the B-to-A direction
      if (!ba_en_n_i[s] && !ba_le_n_i[s])
        a_r6_ba_pass: assert (a_o[h*HALF_W +: HALF_W] == b_i[h*HALF_W +: HALF_W])
          else $error("R6 pass-through broken in half %0d", h);
      if (ba_en_n_i[s] || ba_oe_n_i[s])
        a_r6_a_quiet: assert (!a_oe[h])
          else $error("R6 a_oe set while disabled in half %0d", h);
      // R8: ganged halves share half 0 drive state
      if (gang_i)
        a_r8_gang_drive: assert (b_oe[h] == b_oe[0] && a_oe[h] == a_oe[0])
          else $error("R8 ganged half %0d drives differently", h);
      // R9: a clash needs both directions enabled
      if (clash_o[h])
        a_r9_clash_cause: assert (!ab_en_n_i[s] && !ba_en_n_i[s] && a_oe[h] && b_oe[h])
          else $error("R9 clash without both drivers in half %0d", h);
    end
  end

endmodule

bind latched_xcvr latched_xcvr_chk #(.HALF_W(HALF_W), .N_HALVES(N_HALVES)) i_chk (.*);

// File: tb/test_latched_xcvr.sv
module test_latched_xcvr;

  localparam int HW = 8;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          gang;
  logic [NH-1:0] ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
  logic [BW-1:0] a_in, b_in;
  logic [BW-1:0] a_out, b_out;
  logic [NH-1:0] a_oe, b_oe, clash;

  latched_xcvr #(.HALF_W(HW), .N_HALVES(NH)) i_latched_xcvr (
    .gang_i   (gang),
    .ab_en_n_i(ab_en_n),
    .ab_le_n_i(ab_le_n),
    .ab_oe_n_i(ab_oe_n),
    .ba_en_n_i(ba_en_n),
    .ba_le_n_i(ba_le_n),
    .ba_oe_n_i(ba_oe_n),
    .a_i      (a_in),
    .b_i      (b_in),
    .a_o      (a_out),
    .a_oe     (a_oe),
    .b_o      (b_out),
    .b_oe     (b_oe),
    .clash_o  (clash)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model of the stored contents
  logic [HW-1:0] m_ab [NH];
  logic [HW-1:0] m_ba [NH];
  bit            v_ab [NH];
  bit            v_ba [NH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // settle, update the model, compare every output
  task automatic step();
    #3;
    for (int h = 0; h < NH; h++) begin
      int s;
      s = gang ? 0 : h;
      if (!ab_en_n[s] && !ab_le_n[s]) begin m_ab[h] = a_in[h*HW +: HW]; v_ab[h] = 1'b1; end
      if (!ba_en_n[s] && !ba_le_n[s]) begin m_ba[h] = b_in[h*HW +: HW]; v_ba[h] = 1'b1; end
    end
    for (int h = 0; h < NH; h++) begin
      int  s;
      logic eb, ea;
      s  = gang ? 0 : h;
      eb = !ab_en_n[s] && !ab_oe_n[s];
      ea = !ba_en_n[s] && !ba_oe_n[s];
      if (v_ab[h]) chk("R3 A-to-B contents on b_o", 32'(b_out[h*HW +: HW]), 32'(m_ab[h]));
      if (v_ba[h]) chk("R6 B-to-A contents on a_o", 32'(a_out[h*HW +: HW]), 32'(m_ba[h]));
      chk("R5 b_oe", 32'(b_oe[h]), 32'(eb));
      chk("R6 a_oe", 32'(a_oe[h]), 32'(ea));
      chk("R9 clash", 32'(clash[h]), 32'(eb && ea));
    end
    #1;
  endtask

  // rising controls first, then falling, so nothing opens by accident
  task automatic set_ctrl(input logic [5:0] c0, input logic [5:0] c1);
    logic [NH-1:0] n_aen, n_ale, n_aoe, n_ben, n_ble, n_boe;
    n_aen = {c1[0], c0[0]}; n_ale = {c1[1], c0[1]}; n_aoe = {c1[2], c0[2]};
    n_ben = {c1[3], c0[3]}; n_ble = {c1[4], c0[4]}; n_boe = {c1[5], c0[5]};
    ab_en_n |= n_aen; ab_le_n |= n_ale; ab_oe_n |= n_aoe;
    ba_en_n |= n_ben; ba_le_n |= n_ble; ba_oe_n |= n_boe;
    step();
    ab_en_n = n_aen; ab_le_n = n_ale; ab_oe_n = n_aoe;
    ba_en_n = n_ben; ba_le_n = n_ble; ba_oe_n = n_boe;
    step();
  endtask

  task automatic all_off();
    set_ctrl(6'h3f, 6'h3f);
  endtask

  // control word bits: 0 ab_en_n, 1 ab_le_n, 2 ab_oe_n, 3 ba_en_n, 4 ba_le_n, 5 ba_oe_n
  initial begin
    for (int h = 0; h < NH; h++) begin v_ab[h] = 1'b0; v_ba[h] = 1'b0; end
    gang = 1'b0;
    ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;
    a_in = 16'h0000; b_in = 16'h0000;
    #1;
    step();
    chk("R5 idle b_oe", 32'(b_oe), 32'h0);
    chk("R6 idle a_oe", 32'(a_oe), 32'h0);
    chk("R9 idle clash", 32'(clash), 32'h0);

    // R2 transparency on half 0, A-to-B
    a_in = 16'h1234; step();
    set_ctrl(6'b111_000, 6'h3f);
    chk("R2 pass 34", 32'(b_out[7:0]), 32'h34);
    chk("R5 drive on", 32'(b_oe), 32'h1);
    a_in = 16'h12c7; step();
    chk("R2 follow c7", 32'(b_out[7:0]), 32'hc7);

    // R3 hold after latch-enable rises
    set_ctrl(6'b111_010, 6'h3f);
    a_in = 16'h1255; step();
    chk("R3 hold c7", 32'(b_out[7:0]), 32'hc7);

    // R4 latch-enable ignored with enable high
    set_ctrl(6'b111_111, 6'h3f);
    set_ctrl(6'b111_101, 6'h3f);
    a_in = 16'h1299; step();
    set_ctrl(6'b111_111, 6'h3f);
    set_ctrl(6'b111_010, 6'h3f);
    chk("R4 kept c7", 32'(b_out[7:0]), 32'hc7);
    chk("R5 b_oe after R4", 32'(b_oe[0]), 32'h1);

    // R1 B-to-A loads from port B only
    all_off();
    a_in = 16'haaaa; b_in = 16'h3c5a; step();
    set_ctrl(6'b000_111, 6'h3f);
    chk("R1 a_o from b_i", 32'(a_out[7:0]), 32'h5a);
    chk("R1 b_o untouched", 32'(b_out[7:0]), 32'hc7);

    // R9 clash on half 1 only
    all_off();
    set_ctrl(6'h3f, 6'b000_000);
    chk("R9 clash half1", 32'(clash), 32'h2);
    chk("R7 half0 quiet", 32'({a_oe[0], b_oe[0]}), 32'h0);

    // R8 gang: half 1 controls ignored
    all_off();
    gang = 1'b1; step();
    set_ctrl(6'b111_000, 6'h3f);
    chk("R8 gang b_oe", 32'(b_oe), 32'h3);
    chk("R8 gang pass", 32'(b_out), 32'(a_in));
    all_off();
    gang = 1'b0; step();

    // sweep: every control word on half 0 against a shifted word on half 1
    for (int g = 0; g < 2; g++) begin
      all_off();
      gang = g[0]; step();
      for (int c = 0; c < 64; c++) begin
        logic [5:0] c1;
        c1   = 6'((c * 37 + 11) & 63);
        a_in = 16'(16'ha5c3 ^ (c * 16'h0731));
        b_in = 16'(16'h5e19 + (c * 16'h1b07));
        step();
        set_ctrl(6'(c), c1);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule